// File: doc/BRIEF.md
# Byte-Wide Display Memory Bridge

This block lets a host with only a narrow port drive a 16-bit parallel SRAM and a 16-bit LCD write bus. The host side has an 8-bit data path and four control lines: a 2-bit register select, a write strobe and a read strobe. Each strobe is a one-cycle pulse that is synchronous to `clk`. A 2-to-4 decode of the select picks one of four host registers: the address port, the data port, the copy-count port and a phase-resynchronisation port.

The host sets a 20-bit word address with three byte writes. After that it can stream 16-bit words into SRAM as byte pairs, or read them back as byte pairs. The address counter advances by one after every word. The host can also load a word count. The block then copies that many words from SRAM to the panel without further help from the host. For each word it drives the word onto the LCD bus and pulses the LCD write line low. A busy flag tells the host when the copy has finished. The usual pattern is to set an address once and then move a group of words, for example 256 of them.

Top module: `disp_mem_bridge`

## Requirements
- R1: After a synchronous active-low reset, `sram_addr` is 0, `sram_we_n` and `lcd_wr_n` are 1, `host_dout` is 0 and no copy is in progress.
- R2: Writes to select 0 load the address one byte at a time, lowest byte first. The first write sets bits 7:0, the second sets bits 15:8 and the third sets bits 19:16 from data bits 3:0. Data bits 7:4 of the third byte are ignored. After the third byte the sequence starts again at the first byte.
- R3: The address counter increments by one after each SRAM word write, after each completed word read, and after each word copied to the LCD. It wraps from 0xFFFFF to 0x00000.
- R4: Writes to select 1 pack two bytes into one word, low byte first. In the cycle after the high byte is taken, `sram_we_n` is low for exactly one cycle, `sram_wdata` holds {high, low} and `sram_addr` holds the address of that word.
- R5: Reads on select 1 return the low byte of the SRAM word at the current address, and then its high byte. `host_dout` updates on the clock edge that samples the read strobe. The address advances only after the high byte.
- R6: Writes to select 2 load a 16-bit count, low byte first. The high-byte write starts a copy if the count is nonzero. Each word then takes two cycles. In the first cycle `lcd_wr_n` is low and `lcd_data` holds the SRAM word that was read in the cycle before. In the second cycle `lcd_wr_n` is high and the address advances. There are exactly as many pulses as the count.
- R7: A read on select 2 returns the busy flag in bit 0, with the other bits 0. The flag is 1 from the edge after the count's high byte until the last word has been copied. A count of zero never sets it.
- R8: While busy, writes to selects 0, 1 and 2 and reads on select 1 have no effect. They change neither the address, the SRAM contents, the byte phases nor `host_dout`.
- R9: A write to select 3 returns the address, data and count byte phases to their first byte.
- R10: Reads on select 0 and select 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Host read byte, registered |
| sram_addr | output | 20 | SRAM word address (the auto-increment counter) |
| sram_wdata | output | 16 | SRAM write word |
| sram_rdata | input | 16 | SRAM read word (asynchronous SRAM) |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| lcd_data | output | 16 | LCD pixel word |
| lcd_wr_n | output | 1 | LCD write strobe, active low |

## Verification
The bench drives three kinds of traffic and compares every output against a behavioural model on every clock. Back-to-back word bursts written and then read back show whether the byte order and the write pulse are correct. Bursts that start at 0xFFFFF separate a wrapping counter from one that carries or saturates. Copies of several lengths, including zero, together with host traffic injected during a copy, show whether the strobe count and busy flag are correct and whether the host is properly locked out. It also runs a stray address byte followed by a resync, which shows whether the phases really restart.

// File: rtl/dmb_pkg.sv
// Shared constants and types for the display memory bridge.
// Assumes an 8-bit host byte and a 16-bit memory/panel word.
package dmb_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int N_SEL  = 1 << SEL_W;

    localparam logic [SEL_W-1:0] SEL_ADDR = 2'd0;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CNT  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_SYNC = 2'd3;

    typedef enum logic [1:0] {
        CP_IDLE = 2'd0,
        CP_SET  = 2'd1,
        CP_HOLD = 2'd2
    } cp_state_t;
endpackage

// File: rtl/dmb_sel_decode.sv
// One-of-N decode of the host select, qualified separately by the
// write and read strobes. Assumes strobes are already synchronous.
module dmb_sel_decode #(
    parameter int SEL_W = 2,
    localparam int N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             wr,
    input  logic             rd,
    output logic [N-1:0]     wr_hit,
    output logic [N-1:0]     rd_hit
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        // one output line per register slot
        assign wr_hit[i] = wr && (sel == SEL_W'(i));
        assign rd_hit[i] = rd && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/dmb_addr_ctr.sv
// Word address counter: byte-lane loads from the host and a +1 step.
// A load in the same cycle as a step wins. Bits above ADDR_W in the top
// lane are dropped. Wraps naturally at 2**ADDR_W.
module dmb_addr_ctr #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8,
    localparam int N_LANE = (ADDR_W + BYTE_W - 1) / BYTE_W,
    localparam int IDX_W  = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] lane_mask;
    logic [ADDR_W-1:0] lane_val;

    // place the incoming byte into its lane
    always_comb begin
        lane_mask = ADDR_W'({BYTE_W{1'b1}}) << (int'(load_idx) * BYTE_W);
        lane_val  = ADDR_W'(load_byte) << (int'(load_idx) * BYTE_W);
    end

    // hold, load a lane, or step
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load_en)
            addr <= (addr & ~lane_mask) | (lane_val & lane_mask);
        else if (inc)
            addr <= addr + ADDR_W'(1);
    end
endmodule

// File: rtl/dmb_copy_eng.sv
// SRAM-to-LCD copy sequencer. Takes a two-byte count (low first). A
// nonzero count starts the copy. Each word: SET (drive data, strobe
// low), then HOLD (strobe high, request address step, count down).
// Assumes the count bytes only arrive while idle.
module dmb_copy_eng
    import dmb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_lo_wr,
    input  logic              cnt_hi_wr,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [WORD_W-1:0] sram_rdata,
    output logic              busy,
    output logic              adv,
    output logic [WORD_W-1:0] lcd_data,
    output logic              lcd_wr_n
);
    cp_state_t         st;
    logic [BYTE_W-1:0] cnt_lo;
    logic [WORD_W-1:0] cnt;

    assign busy = (st != CP_IDLE);
    assign adv  = (st == CP_HOLD);

    // count capture and two-phase strobe sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= CP_IDLE;
            cnt_lo   <= '0;
            cnt      <= '0;
            lcd_data <= '0;
            lcd_wr_n <= 1'b1;
        end else begin
            case (st)
                CP_IDLE: begin
                    if (cnt_lo_wr)
                        cnt_lo <= byte_in;
                    if (cnt_hi_wr) begin
                        cnt <= {byte_in, cnt_lo};
                        if ({byte_in, cnt_lo} != '0)
                            st <= CP_SET;
                    end
                end
                CP_SET: begin
                    lcd_data <= sram_rdata;
                    lcd_wr_n <= 1'b0;
                    st       <= CP_HOLD;
                end
                CP_HOLD: begin
                    lcd_wr_n <= 1'b1;
                    cnt      <= cnt - WORD_W'(1);
                    st       <= (cnt == WORD_W'(1)) ? CP_IDLE : CP_SET;
                end
                default: st <= CP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/disp_mem_bridge.sv
// Byte-wide host bridge to a 16-bit SRAM and a 16-bit LCD write bus.
// Assumes single-cycle synchronous host strobes, never a read and a write
// together, and an asynchronous SRAM whose read data settles within a cycle.
module disp_mem_bridge
    import dmb_pkg::*;
#(
    parameter int ADDR_W  = 20,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int N_AB   = (ADDR_W + BYTE_W - 1) / BYTE_W,
    localparam int APOS_W = (N_AB > 1) ? $clog2(N_AB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [WORD_W-1:0] sram_wdata,
    input  logic [WORD_W-1:0] sram_rdata,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [WORD_W-1:0] lcd_data,
    output logic              lcd_wr_n
);
    logic [N_SEL-1:0]  wr_hit, rd_hit;
    logic              busy, adv;
    logic              addr_wr, data_wr, data_rd, cnt_wr, sync_wr;
    logic [APOS_W-1:0] apos;
    logic              dpos, cpos;
    logic [BYTE_W-1:0] lo_byte;
    logic              we_act;
    logic              inc;

    dmb_sel_decode #(.SEL_W(SEL_W)) u_dec (
        .sel(host_sel), .wr(host_wr), .rd(host_rd),
        .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    // host accesses that are locked out while a copy runs
    assign addr_wr = wr_hit[SEL_ADDR] && !busy;
    assign data_wr = wr_hit[SEL_DATA] && !busy;
    assign data_rd = rd_hit[SEL_DATA] && !busy;
    assign cnt_wr  = wr_hit[SEL_CNT]  && !busy;
    assign sync_wr = wr_hit[SEL_SYNC];

    assign inc = we_act || (data_rd && dpos) || adv;

    dmb_addr_ctr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load_en(addr_wr), .load_idx(apos), .load_byte(host_din),
        .inc(inc), .addr(sram_addr)
    );

    dmb_copy_eng #(.BYTE_W(BYTE_W)) u_copy (
        .clk(clk), .rst_n(rst_n),
        .cnt_lo_wr(cnt_wr && !cpos), .cnt_hi_wr(cnt_wr && cpos),
        .byte_in(host_din), .sram_rdata(sram_rdata),
        .busy(busy), .adv(adv),
        .lcd_data(lcd_data), .lcd_wr_n(lcd_wr_n)
    );

    // address byte phase
    always_ff @(posedge clk) begin
        if (!rst_n || sync_wr)
            apos <= '0;
        else if (addr_wr)
            apos <= (apos == APOS_W'(N_AB - 1)) ? '0 : apos + APOS_W'(1);
    end

    // data and count byte phases
    always_ff @(posedge clk) begin
        if (!rst_n || sync_wr) begin
            dpos <= 1'b0;
            cpos <= 1'b0;
        end else begin
            if (data_wr || data_rd)
                dpos <= !dpos;
            if (cnt_wr)
                cpos <= !cpos;
        end
    end

    // byte-to-word packing and the one-cycle write pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_byte    <= '0;
            sram_wdata <= '0;
            we_act     <= 1'b0;
        end else begin
            we_act <= data_wr && dpos;
            if (data_wr && !dpos)
                lo_byte <= host_din;
            if (data_wr && dpos)
                sram_wdata <= {host_din, lo_byte};
        end
    end

    assign sram_we_n = !we_act;
    assign sram_oe_n = we_act;

    // host read byte register
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_dout <= '0;
        else if (data_rd)
            host_dout <= dpos ? sram_rdata[WORD_W-1:BYTE_W] : sram_rdata[BYTE_W-1:0];
        else if (rd_hit[SEL_CNT])
            host_dout <= {{(BYTE_W-1){1'b0}}, busy};
        else if (rd_hit[SEL_ADDR] || rd_hit[SEL_SYNC])
            host_dout <= '0;
    end
endmodule

// File: rtl/dmb_checks.sv
// Temporal checks on the bridge's memory and panel strobes.
// Bound into every instance of disp_mem_bridge.
module dmb_checks #(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_we_n,
    input logic [WORD_W-1:0] sram_rdata,
    input logic [WORD_W-1:0] lcd_data,
    input logic              lcd_wr_n
);
    // R4: SRAM write pulse lasts exactly one cycle
    a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);

    // R3: address steps (with wrap) right after each SRAM write
    a_r3_step_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_addr == $past(sram_addr) + ADDR_W'(1));

    // R6: LCD strobe is a single-cycle low pulse
    a_r6_lcd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |=> lcd_wr_n);

    // R6: LCD data holds through the strobe's rising edge
    a_r6_lcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |=> $stable(lcd_data));

    // R6: panel word is the SRAM word read just before the strobe
    a_r6_lcd_from_sram: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_wr_n) |-> lcd_data == $past(sram_rdata));

    // R3: address steps after each copied word
    a_r3_step_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |=> sram_addr == $past(sram_addr) + ADDR_W'(1));

    // R8: host writes and panel copies never overlap
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !lcd_wr_n));
endmodule

bind disp_mem_bridge dmb_checks #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr), .sram_we_n(sram_we_n),
    .sram_rdata(sram_rdata), .lcd_data(lcd_data), .lcd_wr_n(lcd_wr_n)
);

// File: tb/tb_disp_mem_bridge.sv
module tb_disp_mem_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic [19:0] sram_addr;
    logic [15:0] sram_wdata, sram_rdata, lcd_data;
    logic        sram_we_n, sram_oe_n, lcd_wr_n;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] mem [0:4095];
    assign sram_rdata = mem[sram_addr[11:0]];

    disp_mem_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_din(host_din), .host_dout(host_dout),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .lcd_data(lcd_data), .lcd_wr_n(lcd_wr_n)
    );

    always #(CLK_PERIOD / 2) clk = !clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [19:0] m_addr;
    logic [1:0]  m_apos;
    logic        m_dpos, m_cpos, m_we;
    logic [7:0]  m_lo, m_clo, m_out;
    logic [15:0] m_wd, m_cnt, m_lcd, m_din;
    int          m_st, st0;
    logic        m_lwr, n_we, ld, inc;
    logic        model_on = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_addr = '0; m_apos = '0; m_dpos = 0; m_cpos = 0; m_we = 0;
            m_lo = '0; m_clo = '0; m_out = '0; m_wd = '0; m_cnt = '0;
            m_lcd = '0; m_st = 0; m_lwr = 1;
        end else begin
            m_din = mem[m_addr[11:0]];
            st0 = m_st;
            inc = m_we; ld = 0; n_we = 0;
            if (host_wr && host_sel == 2'd3) begin
                m_apos = 0; m_dpos = 0; m_cpos = 0;
            end else if (host_wr && st0 == 0) begin
                case (host_sel)
                    2'd0: begin
                        ld = 1;
                        if (m_apos == 0) m_addr[7:0] = host_din;
                        else if (m_apos == 1) m_addr[15:8] = host_din;
                        else m_addr[19:16] = host_din[3:0];
                        m_apos = (m_apos == 2) ? 2'd0 : m_apos + 2'd1;
                    end
                    2'd1: begin
                        if (!m_dpos) m_lo = host_din;
                        else begin m_wd = {host_din, m_lo}; n_we = 1; end
                        m_dpos = !m_dpos;
                    end
                    default: begin
                        if (!m_cpos) m_clo = host_din;
                        else begin
                            m_cnt = {host_din, m_clo};
                            if (m_cnt != 0) m_st = 1;
                        end
                        m_cpos = !m_cpos;
                    end
                endcase
            end
            if (host_rd) begin
                if (host_sel == 2'd1) begin
                    if (st0 == 0) begin
                        if (!m_dpos) m_out = m_din[7:0];
                        else begin m_out = m_din[15:8]; inc = 1; end
                        m_dpos = !m_dpos;
                    end
                end else if (host_sel == 2'd2) m_out = {7'd0, st0 != 0};
                else m_out = '0;
            end
            if (st0 == 1) begin
                m_lcd = m_din; m_lwr = 0; m_st = 2;
            end else if (st0 == 2) begin
                m_lwr = 1; inc = 1; m_cnt = m_cnt - 1;
                m_st = (m_cnt == 0) ? 0 : 1;
            end
            if (inc && !ld) m_addr = m_addr + 20'd1;
            m_we = n_we;
            if (!sram_we_n) mem[sram_addr[11:0]] = sram_wdata;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            chk(sram_addr == m_addr, "R3 sram_addr", 32'(sram_addr), 32'(m_addr));
            chk(sram_we_n == !m_we, "R4 sram_we_n", 32'(sram_we_n), 32'(!m_we));
            if (!sram_we_n)
                chk(sram_wdata == m_wd, "R4 sram_wdata", 32'(sram_wdata), 32'(m_wd));
            chk(host_dout == m_out, "R5 host_dout", 32'(host_dout), 32'(m_out));
            chk(lcd_wr_n == m_lwr, "R6 lcd_wr_n", 32'(lcd_wr_n), 32'(m_lwr));
            chk(lcd_data == m_lcd, "R6 lcd_data", 32'(lcd_data), 32'(m_lcd));
        end
    end

    // capture of panel words on each strobe rising edge
    logic [15:0] lcd_q[$];
    always @(posedge lcd_wr_n) if (rst_n) lcd_q.push_back(lcd_data);

    // watchdog
    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- host tasks ----------------
    task automatic hwr(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        host_sel = s; host_din = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] s);
        @(posedge clk); #1;
        host_sel = s; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic set_addr(input logic [19:0] a);
        hwr(2'd0, a[7:0]); hwr(2'd0, a[15:8]); hwr(2'd0, {4'd0, a[19:16]});
    endtask

    task automatic wr_word(input logic [15:0] w);
        hwr(2'd1, w[7:0]); hwr(2'd1, w[15:8]);
    endtask

    task automatic wait_idle(output int polls);
        polls = 0;
        do begin hrd(2'd2); polls++; end while (host_dout[0] && polls < 1000);
    endtask

    logic [15:0] words [0:7];
    logic [15:0] rd_w;
    int polls;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 16'h0137) ^ 16'h5A00;
        for (int i = 0; i < 8; i++) words[i] = 16'(16'hC0DE + i * 16'h1111);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sram_addr == 0, "R1 addr", 32'(sram_addr), 0);
        chk(sram_we_n && lcd_wr_n, "R1 strobes", {sram_we_n, lcd_wr_n}, 3);
        chk(host_dout == 0, "R1 dout", 32'(host_dout), 0);
        model_on = 1'b1;
        hrd(2'd2);
        chk(host_dout == 0, "R1 not busy", 32'(host_dout), 0);

        // R2: three-byte load, upper nibble of third byte ignored
        hwr(2'd0, 8'h34); hwr(2'd0, 8'h12); hwr(2'd0, 8'hF5);
        @(negedge clk);
        chk(sram_addr == 20'h51234, "R2 addr load", 32'(sram_addr), 32'h51234);

        // R4: burst write, R5: read back
        set_addr(20'h00100);
        for (int i = 0; i < 4; i++) wr_word(words[i]);
        repeat (2) @(posedge clk);
        for (int i = 0; i < 4; i++)
            chk(mem[12'h100 + i] == words[i], "R4 stored word", 32'(mem[12'h100 + i]), 32'(words[i]));
        @(negedge clk);
        chk(sram_addr == 20'h00104, "R3 addr after burst", 32'(sram_addr), 32'h104);
        set_addr(20'h00100);
        for (int i = 0; i < 4; i++) begin
            hrd(2'd1); rd_w[7:0] = host_dout;
            hrd(2'd1); rd_w[15:8] = host_dout;
            chk(rd_w == words[i], "R5 readback", 32'(rd_w), 32'(words[i]));
        end

        // R3: wrap from the top address
        set_addr(20'hFFFFF);
        wr_word(16'hBEEF); wr_word(16'hF00D);
        repeat (2) @(posedge clk);
        chk(mem[12'hFFF] == 16'hBEEF, "R3 last word", 32'(mem[12'hFFF]), 32'hBEEF);
        chk(mem[0] == 16'hF00D, "R3 wrapped word", 32'(mem[0]), 32'hF00D);
        @(negedge clk);
        chk(sram_addr == 20'd1, "R3 wrap addr", 32'(sram_addr), 1);

        // R6, R7: copy five words, poll busy
        set_addr(20'h00100);
        lcd_q.delete();
        hwr(2'd2, 8'd5); hwr(2'd2, 8'd0);
        hrd(2'd2);
        chk(host_dout == 8'd1, "R7 busy during copy", 32'(host_dout), 1);
        // R8: host traffic while busy is ignored
        hwr(2'd0, 8'h77); hwr(2'd1, 8'h11); hwr(2'd1, 8'h22);
        wait_idle(polls);
        chk(host_dout == 8'd0, "R7 busy cleared", 32'(host_dout), 0);
        chk(lcd_q.size() == 5, "R6 strobe count", 32'(lcd_q.size()), 5);
        for (int i = 0; i < 5 && i < lcd_q.size(); i++)
            chk(lcd_q[i] == (i < 4 ? words[i] : mem[12'h104]), "R6 panel word",
                32'(lcd_q[i]), 32'(i < 4 ? words[i] : mem[12'h104]));
        @(negedge clk);
        chk(sram_addr == 20'h00105, "R8 addr untouched by locked writes", 32'(sram_addr), 32'h105);
        chk(mem[12'h100] == words[0], "R8 memory untouched", 32'(mem[12'h100]), 32'(words[0]));

        // R7: zero count never starts
        lcd_q.delete();
        hwr(2'd2, 8'd0); hwr(2'd2, 8'd0);
        hrd(2'd2);
        chk(host_dout == 8'd0, "R7 zero count idle", 32'(host_dout), 0);
        repeat (4) @(posedge clk);
        chk(lcd_q.size() == 0, "R7 zero count no strobe", 32'(lcd_q.size()), 0);

        // R9: stray byte then resync
        hwr(2'd0, 8'hAA);
        hwr(2'd3, 8'h00);
        set_addr(20'h3C0DE);
        @(negedge clk);
        chk(sram_addr == 20'h3C0DE, "R9 resync addr", 32'(sram_addr), 32'h3C0DE);

        // R10: selects 0 and 3 read as zero
        set_addr(20'h00100);
        hrd(2'd1);
        hrd(2'd0);
        chk(host_dout == 0, "R10 sel0 read", 32'(host_dout), 0);
        hrd(2'd1);
        hrd(2'd3);
        chk(host_dout == 0, "R10 sel3 read", 32'(host_dout), 0);

        // R6: a longer copy of eight words
        set_addr(20'h00200);
        for (int i = 0; i < 8; i++) wr_word(words[7 - i]);
        set_addr(20'h00200);
        lcd_q.delete();
        hwr(2'd2, 8'd8); hwr(2'd2, 8'd0);
        wait_idle(polls);
        chk(lcd_q.size() == 8, "R6 long copy count", 32'(lcd_q.size()), 8);
        for (int i = 0; i < 8 && i < lcd_q.size(); i++)
            chk(lcd_q[i] == words[7 - i], "R6 long copy word", 32'(lcd_q[i]), 32'(words[7 - i]));

        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule